// File: doc/BRIEF.md
# Maskable Interrupt Controller with Selectable Output Modes

This block gathers single-cycle event pulses from up to NUM_SRC sources, for example end of message, time-tag counter wrap and error detection. It records them in a status register and drives one interrupt request pin toward a host. The host reaches four word-wide locations through a simple synchronous strobe interface: an enable mask, a configuration word, the read-only status word and a write-only clear command.

The configuration word selects one of three pin behaviours and one of two status-capture policies. In the standard policy a source is recorded only while its mask bit is set. In the enhanced policy every source is recorded whatever its mask bit holds. Under either policy the pin answers only to sources that are enabled. The pin can emit a one-cycle pulse, hold a level until software issues the clear command, or hold a level that a read of the status word removes.

Top module: `intr_hub`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the mask, configuration and status words read back as zero and irq is low. Zero configuration selects the standard policy and level-until-clear pin behaviour.
- R2: In the standard policy (configuration bit 2 = 0) a pulse on cond_i[k] while mask bit k is 0 leaves status bit k at 0 and irq low.
- R3: In the standard policy a pulse on cond_i[k] while mask bit k is 1 sets status bit k from the following cycle. The status word is read at address 2.
- R4: In the enhanced policy (configuration bit 2 = 1) a pulse on cond_i[k] sets status bit k whatever mask bit k holds. A status bit whose mask bit is 0 never raises irq.
- R5: In level-until-clear mode (configuration bits [1:0] = 0) irq rises one cycle after an enabled source is captured and stays high until a clear command.
- R6: A write to address 3 (the clear command) zeroes every status bit and drops a level-mode irq on the next cycle. A source pulsing in the same cycle is still captured.
- R7: In pulse mode (configuration bits [1:0] = 1) irq is high for exactly one cycle, one cycle after a pulse on an enabled source whose status bit was not already set. A repeat pulse on an already-set bit produces no pulse.
- R8: In read-clear mode (configuration bits [1:0] = 2) a read at address 2 returns the status before clearing, and from the next cycle the status is zero and irq is low.
- R9: In read-clear mode a source pulsing in the same cycle as the status read is kept in status and keeps irq high.
- R10: Writes at address 0 (mask) and address 1 (configuration, bits [2:0]) read back at the same addresses.
- R11: A status read in a mode other than read-clear leaves the status word unchanged.
- R12: A write at address 2 has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_i | input | NUM_SRC | One-cycle event pulses, one bit per source |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Register address: 0 mask, 1 config, 2 status, 3 clear |
| wdata | input | NUM_SRC | Host write data |
| rdata | output | NUM_SRC | Read data for addr, valid in the strobe cycle |
| irq | output | 1 | Interrupt request pin |

## Verification
The bench aims at the cycle in which a status read meets a fresh event in read-clear mode. A design that lets the clear win would lose that event, and both the later status read and the irq level would show it. It fires masked sources in both policies: a design that applies the mask the wrong way round would either record masked events in standard policy or raise irq for them in enhanced policy. In pulse mode it repeats an event on a bit that is already set, where a design keyed on the raw input rather than on new status bits would pulse a second time. It also reads status in level mode and writes to the status address, which catches a design that clears status on every read or lets the host overwrite it.

// File: rtl/intr_hub_pkg.sv
// Shared types for the interrupt hub: pin behaviour codes, register
// addresses and the packed configuration word.
package intr_hub_pkg;
    typedef enum logic [1:0] {
        PIN_LEVEL_SW = 2'd0,
        PIN_PULSE    = 2'd1,
        PIN_LEVEL_RD = 2'd2,
        PIN_RSVD     = 2'd3
    } pin_mode_e;

    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_CLR  = 2'd3;

    typedef struct packed {
        logic      enhanced;
        pin_mode_e mode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/intr_hub_regs.sv
// Host-side register file: holds the mask and configuration words and
// decodes the clear command and the clearing status read.
// Assumes single-cycle strobes and at most one of wr_en / rd_en per cycle.
module intr_hub_regs
    import intr_hub_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask_q,
    output cfg_t               cfg_q,
    output logic               clr_req
);
    // Mask and configuration storage, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_MASK) mask_q <= wdata;
            if (addr == ADDR_CFG) begin
                cfg_q.enhanced <= wdata[2];
                cfg_q.mode     <= pin_mode_e'(wdata[1:0]);
            end
        end
    end

    // Clear request: explicit command, or a status read in read-clear mode.
    always_comb begin
        clr_req = (wr_en && addr == ADDR_CLR)
               || (rd_en && addr == ADDR_STAT && cfg_q.mode == PIN_LEVEL_RD);
    end
endmodule

// File: rtl/intr_hub_status.sv
// Status capture: records incoming events through the policy gate and
// reports which bits become newly set this cycle.
// Assumes a clear and a fresh event in one cycle keep the fresh event.
module intr_hub_status #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic               enhanced,
    input  logic               clr_req,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] new_bits
);
    logic [NUM_SRC-1:0] gate;
    logic [NUM_SRC-1:0] base;
    logic [NUM_SRC-1:0] captured;

    // Capture gate and cleared base for the next status value.
    always_comb begin
        gate     = enhanced ? {NUM_SRC{1'b1}} : mask_q;
        base     = clr_req ? '0 : status_q;
        captured = cond_i & gate;
        new_bits = captured & ~base;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= base | captured;
    end
endmodule

// File: rtl/intr_hub_pin.sv
// Interrupt pin generator: one-cycle pulse per newly set enabled bit, or a
// level that follows the enabled status bits.
// Assumes new_bits is already gated by the capture policy.
module intr_hub_pin
    import intr_hub_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pin_mode_e          mode,
    input  logic [NUM_SRC-1:0] new_bits,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic               irq
);
    logic pulse_q;

    // Pulse register: high one cycle after an enabled bit is newly set.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (mode == PIN_PULSE) && |(new_bits & mask_q);
    end

    // Output select between pulse and level behaviour.
    always_comb begin
        irq = (mode == PIN_PULSE) ? pulse_q : |(status_q & mask_q);
    end
endmodule

// File: rtl/intr_hub.sv
// Top of the interrupt hub: ties the register file, status capture and pin
// generator together and provides the host read path.
// Assumes rdata is sampled by the host in the strobe cycle.
module intr_hub
    import intr_hub_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq
);
    localparam int PAD_W = NUM_SRC - CFG_W;

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] new_bits;
    cfg_t               cfg_q;
    logic               clr_req;

    intr_hub_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .mask_q  (mask_q),
        .cfg_q   (cfg_q),
        .clr_req (clr_req)
    );

    intr_hub_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_i),
        .mask_q   (mask_q),
        .enhanced (cfg_q.enhanced),
        .clr_req  (clr_req),
        .status_q (status_q),
        .new_bits (new_bits)
    );

    intr_hub_pin #(.NUM_SRC(NUM_SRC)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_q.mode),
        .new_bits (new_bits),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    // Host read mux; the clear location reads as zero.
    always_comb begin
        unique case (addr)
            ADDR_MASK: rdata = mask_q;
            ADDR_CFG:  rdata = {{PAD_W{1'b0}}, cfg_q};
            ADDR_STAT: rdata = status_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_hub_chk.sv
// Property checker for the interrupt hub, attached by bind below.
// Observes ports and the top-level mask, configuration and status words.
module intr_hub_chk
    import intr_hub_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] cond_i,
    input logic               wr_en,
    input logic               rd_en,
    input logic [1:0]         addr,
    input logic               irq,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q,
    input cfg_t               cfg_q
);
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && mask_q == '0 && cfg_q == '0)); // R1

    AST_STD_NO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.enhanced |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0)); // R2

    AST_LEVEL_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode != PIN_PULSE && irq) |-> ((status_q & mask_q) != '0)); // R4

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_q.mode == PIN_PULSE && $past(cfg_q.mode) == PIN_PULSE)
            |-> (($past(cond_i) & $past(mask_q)) != '0)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CLR) |=> ((status_q & ~$past(cond_i)) == '0)); // R6

    AST_READ_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_STAT && cfg_q.mode == PIN_LEVEL_RD)
            |=> ((status_q & ~$past(cond_i)) == '0)); // R8
endmodule

bind intr_hub intr_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (cond_i),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .irq      (irq),
    .status_q (status_q),
    .mask_q   (mask_q),
    .cfg_q    (cfg_q)
);

// File: tb/intr_hub_test.sv
// Directed bench for the interrupt hub: one task per scenario.
module intr_hub_test;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cond_i = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    intr_hub #(.NUM_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [N-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    // Read with an optional event in the same cycle.
    task automatic rd(logic [1:0] a, logic [N-1:0] ev, output logic [N-1:0] val);
        addr = a; rd_en = 1'b1; cond_i = ev;
        #1 val = rdata;
        tick();
        rd_en = 1'b0; cond_i = '0;
    endtask

    task automatic fire(logic [N-1:0] ev);
        cond_i = ev;
        tick();
        cond_i = '0;
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 irq", {15'd0, irq}, 16'h0);
        rd(2'd0, '0, v); check("R1 mask", v, 16'h0);
        rd(2'd1, '0, v); check("R1 cfg", v, 16'h0);
        rd(2'd2, '0, v); check("R1 status", v, 16'h0);
    endtask

    task automatic t_standard();
        logic [N-1:0] v;
        wr(2'd0, 16'h0005);
        rd(2'd0, '0, v); check("R10 mask readback", v, 16'h0005);
        fire(16'h0002);
        check("R2 irq masked", {15'd0, irq}, 16'h0);
        rd(2'd2, '0, v); check("R2 status masked", v, 16'h0);
        fire(16'h0004);
        check("R5 irq level", {15'd0, irq}, 16'h1);
        rd(2'd2, '0, v); check("R3 status set", v, 16'h0004);
        rd(2'd2, '0, v); check("R11 status kept after read", v, 16'h0004);
        check("R5 irq held", {15'd0, irq}, 16'h1);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, '0, v); check("R12 status write ignored", v, 16'h0004);
        wr(2'd3, 16'h0000);
        check("R6 irq after clear", {15'd0, irq}, 16'h0);
        rd(2'd2, '0, v); check("R6 status after clear", v, 16'h0);
        // Clear with a fresh enabled event in the same cycle.
        addr = 2'd3; wr_en = 1'b1; cond_i = 16'h0001;
        tick();
        wr_en = 1'b0; cond_i = '0;
        rd(2'd2, '0, v); check("R6 event during clear kept", v, 16'h0001);
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_enhanced();
        logic [N-1:0] v;
        wr(2'd1, 16'h0004);
        rd(2'd1, '0, v); check("R10 cfg readback", v, 16'h0004);
        wr(2'd0, 16'h0001);
        fire(16'h0100);
        check("R4 irq masked", {15'd0, irq}, 16'h0);
        rd(2'd2, '0, v); check("R4 status captured", v, 16'h0100);
        fire(16'h0001);
        check("R4 irq enabled", {15'd0, irq}, 16'h1);
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_pulse();
        logic [N-1:0] v;
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'h0003);
        fire(16'h0001);
        check("R7 pulse high", {15'd0, irq}, 16'h1);
        tick();
        check("R7 pulse one cycle", {15'd0, irq}, 16'h0);
        fire(16'h0001);
        check("R7 no pulse on set bit", {15'd0, irq}, 16'h0);
        fire(16'h0002);
        check("R7 pulse second bit", {15'd0, irq}, 16'h1);
        fire(16'h0004);
        check("R7 no pulse masked", {15'd0, irq}, 16'h0);
        rd(2'd2, '0, v); check("R7 status", v, 16'h0003);
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_autoclear();
        logic [N-1:0] v;
        wr(2'd1, 16'h0002);
        wr(2'd0, 16'hFFFF);
        fire(16'h0010);
        check("R8 irq set", {15'd0, irq}, 16'h1);
        rd(2'd2, '0, v); check("R8 read pre-clear", v, 16'h0010);
        check("R8 irq dropped", {15'd0, irq}, 16'h0);
        rd(2'd2, '0, v); check("R8 status cleared", v, 16'h0);
        fire(16'h0020);
        rd(2'd2, 16'h0040, v); check("R9 read value", v, 16'h0020);
        check("R9 irq kept", {15'd0, irq}, 16'h1);
        rd(2'd2, '0, v); check("R9 event kept", v, 16'h0040);
        check("R8 irq after second read", {15'd0, irq}, 16'h0);
    endtask

    initial begin
        t_reset();
        t_standard();
        t_enhanced();
        t_pulse();
        t_autoclear();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule